// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is a board-level system controller register bank on a simple 32-bit register read/write bus. It offers a read-only board identifier, an LED output register, two configuration scratch words, two flag registers with separate set and clear addresses, a free-running count that advances at a fixed tick rate, and a status word that mirrors the card-detect and write-protect pins.

A reset-level register can raise a system reset request. It accepts writes only after software has stored a fixed unlock key in the lock register. Whether the reset-level register exists, and which of its bits fires the request, depends on the board field (bits 27:16) of the identifier parameter. The same field sets where the write-protect pin appears in the status word. Accesses to offsets that are not mapped return zero, leave state unchanged and pulse a bad-address strobe.

A request is a single cycle with `req_i` high, `we_i` selecting a write. Read data is registered: it appears on `rdata_o` in the cycle after the request and is held until the next read.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the LED, lock, both configuration words, both flag registers and the reset-level register read zero, and `reset_req_o` and `bad_addr_o` are low.
- R2: Offset 0x000 reads the `ID_VALUE` parameter and offset 0x044 reads 1. Writes to either offset change nothing.
- R3: Offset 0x008 (LED, also driven on `led_o`), 0x028 and 0x02C are plain read/write words.
- R4: A write of exactly 0x0000A05F to offset 0x020 stores 0xA05F. Any other write stores wdata[15:0] with bit 15 cleared. Read bits 31:16 are zero.
- R5: A write to 0x030 ORs wdata into the primary flags and a write to 0x034 clears the flag bits that are set in wdata. Offset 0x030 reads the flags and 0x034 reads zero.
- R6: Offsets 0x038 (read and set) and 0x03C (clear, reads zero) behave the same way for the second flag register.
- R7: A write to 0x040 updates the reset-level register only when the lock register holds 0xA05F and the board field is 0x100, 0x178 or 0x182. For any other board field the register stays zero.
- R8: An accepted write to 0x040 gives a one-cycle `reset_req_o` pulse in the next cycle when its trigger bit is set. The trigger bit is bit 8 for board 0x100 and bit 2 for boards 0x178 and 0x182.
- R9: Offset 0x05C reads a count that advances at `TICK_HZ` from a `CLK_HZ` clock. With the defaults, any 250-cycle window holds exactly 30 increments.
- R10: Offset 0x048 reads the registered pin states. Bit 0 is `card_detect_i`. Write-protect is at bit 2 for boards 0x100 and 0x140 and at bit 1 otherwise. All other bits are zero and writes are ignored.
- R11: Unmapped or misaligned offsets read zero and ignore writes, and `bad_addr_o` pulses for one cycle in the cycle after the access.
- R12: `rdata_o` changes only in the cycle after a read request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| led_o | output | 32 | LED register contents |
| card_detect_i | input | 1 | Card present pin |
| write_prot_i | input | 1 | Write-protect pin |
| reset_req_o | output | 1 | One-cycle system reset request |
| bad_addr_o | output | 1 | One-cycle unmapped-access strobe |

## Verification
The assertions assume that each access lasts one cycle and that the pin inputs change only between clock edges. Several of them tie `rdata_o` to the address of the previous cycle's request, so the stimulus drives every request on a falling edge, holds it for exactly one cycle and then deasserts it. The bench instantiates three board variants (0x100, 0x182, 0x190) on one shared bus, so each access checks the trigger bit, the write-protect position and the ignored-write variant together.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_A05F;

  localparam int unsigned OFF_ID     = 'h000;
  localparam int unsigned OFF_LED    = 'h008;
  localparam int unsigned OFF_LOCK   = 'h020;
  localparam int unsigned OFF_CFG0   = 'h028;
  localparam int unsigned OFF_CFG1   = 'h02C;
  localparam int unsigned OFF_FLGS   = 'h030;
  localparam int unsigned OFF_FLGC   = 'h034;
  localparam int unsigned OFF_NVS    = 'h038;
  localparam int unsigned OFF_NVC    = 'h03C;
  localparam int unsigned OFF_RSTLVL = 'h040;
  localparam int unsigned OFF_ONE    = 'h044;
  localparam int unsigned OFF_STAT   = 'h048;
  localparam int unsigned OFF_TICK   = 'h05C;

  localparam logic [11:0] BRD_A = 12'h100;
  localparam logic [11:0] BRD_B = 12'h140;
  localparam logic [11:0] BRD_C = 12'h178;
  localparam logic [11:0] BRD_D = 12'h182;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_LED, SEL_LOCK, SEL_CFG0, SEL_CFG1, SEL_FLGS,
    SEL_FLGC, SEL_NVS, SEL_NVC, SEL_RSTLVL, SEL_ONE, SEL_STAT, SEL_TICK
  } sel_e;

  function automatic logic rstlvl_writable(logic [11:0] brd);
    return (brd == BRD_A) || (brd == BRD_C) || (brd == BRD_D);
  endfunction

  function automatic int unsigned rst_trig_idx(logic [11:0] brd);
    return (brd == BRD_A) ? 8 : 2;
  endfunction

  function automatic int unsigned wp_idx(logic [11:0] brd);
    return ((brd == BRD_A) || (brd == BRD_B)) ? 2 : 1;
  endfunction
endpackage

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (set_i) q <= q | data_i;
    else if (clr_i) q <= q & ~data_i;
  end

  assign q_o = q;
endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock #(
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [31:0]   wdata_i,
  output logic [LW-1:0] q_o,
  output logic          open_o
);
  import sysctl_pkg::*;

  logic [LW-1:0] q;

  // non-key values lose the top bit so they can never equal the key
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (wr_i) begin
      if (wdata_i == UNLOCK_KEY) q <= UNLOCK_KEY[LW-1:0];
      else                       q <= {1'b0, wdata_i[LW-2:0]};
    end
  end

  assign q_o    = q;
  assign open_o = (q == UNLOCK_KEY[LW-1:0]);
endmodule

// File: rtl/sysctl_tick.sv
module sysctl_tick #(
  parameter int unsigned CLK_HZ  = 200_000_000,
  parameter int unsigned TICK_HZ = 24_000_000,
  parameter int unsigned CNT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned ACC_W = $clog2(CLK_HZ + TICK_HZ) + 1;
  localparam logic [ACC_W-1:0] CLK_V  = ACC_W'(CLK_HZ);
  localparam logic [ACC_W-1:0] TICK_V = ACC_W'(TICK_HZ);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_nxt;
  logic [CNT_W-1:0] cnt;

  assign acc_nxt = acc + TICK_V;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc <= '0;
      cnt <= '0;
    end else if (acc_nxt >= CLK_V) begin
      acc <= acc_nxt - CLK_V;
      cnt <= cnt + 1'b1;
    end else begin
      acc <= acc_nxt;
    end
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [31:0] ID_VALUE = 32'h0100_0000,
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned TICK_HZ  = 24_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [31:0]       led_o,
  input  logic              card_detect_i,
  input  logic              write_prot_i,
  output logic              reset_req_o,
  output logic              bad_addr_o
);
  import sysctl_pkg::*;

  localparam int unsigned WORD_W   = ADDR_W - 2;
  localparam logic [11:0] BOARD    = ID_VALUE[27:16];
  localparam bit          RST_WR   = rstlvl_writable(BOARD);
  localparam int unsigned TRIG_IDX = rst_trig_idx(BOARD);
  localparam int unsigned WP_IDX   = wp_idx(BOARD);
  localparam int unsigned LOCK_W   = 16;
  localparam int unsigned NFLAG    = 2;
  localparam int unsigned STAT_W   = 3;

  logic [WORD_W-1:0] word;
  sel_e              sel;
  logic              rd_en, wr_en;

  assign word  = addr_i[ADDR_W-1:2];
  assign rd_en = req_i && !we_i;
  assign wr_en = req_i && we_i;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      unique case (word)
        WORD_W'(OFF_ID     >> 2): sel = SEL_ID;
        WORD_W'(OFF_LED    >> 2): sel = SEL_LED;
        WORD_W'(OFF_LOCK   >> 2): sel = SEL_LOCK;
        WORD_W'(OFF_CFG0   >> 2): sel = SEL_CFG0;
        WORD_W'(OFF_CFG1   >> 2): sel = SEL_CFG1;
        WORD_W'(OFF_FLGS   >> 2): sel = SEL_FLGS;
        WORD_W'(OFF_FLGC   >> 2): sel = SEL_FLGC;
        WORD_W'(OFF_NVS    >> 2): sel = SEL_NVS;
        WORD_W'(OFF_NVC    >> 2): sel = SEL_NVC;
        WORD_W'(OFF_RSTLVL >> 2): sel = SEL_RSTLVL;
        WORD_W'(OFF_ONE    >> 2): sel = SEL_ONE;
        WORD_W'(OFF_STAT   >> 2): sel = SEL_STAT;
        WORD_W'(OFF_TICK   >> 2): sel = SEL_TICK;
        default:                  sel = SEL_NONE;
      endcase
    end
  end

  // plain read/write words
  logic [31:0] led_q, cfg0_q, cfg1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q  <= '0;
      cfg0_q <= '0;
      cfg1_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_LED)  led_q  <= wdata_i;
      if (sel == SEL_CFG0) cfg0_q <= wdata_i;
      if (sel == SEL_CFG1) cfg1_q <= wdata_i;
    end
  end

  assign led_o = led_q;

  // lock
  logic [LOCK_W-1:0] lock_q;
  logic              lock_open;

  sysctl_lock #(.LW(LOCK_W)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en && (sel == SEL_LOCK)),
    .wdata_i (wdata_i),
    .q_o     (lock_q),
    .open_o  (lock_open)
  );

  // flag banks: 0 = primary, 1 = second
  logic [NFLAG-1:0] flg_set, flg_clr;
  logic [31:0]      flg_q [NFLAG];

  assign flg_set[0] = wr_en && (sel == SEL_FLGS);
  assign flg_clr[0] = wr_en && (sel == SEL_FLGC);
  assign flg_set[1] = wr_en && (sel == SEL_NVS);
  assign flg_clr[1] = wr_en && (sel == SEL_NVC);

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sysctl_setclr #(.W(DATA_W)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flg_set[g]),
      .clr_i  (flg_clr[g]),
      .data_i (wdata_i),
      .q_o    (flg_q[g])
    );
  end

  // reset level
  logic [31:0] rstlvl_q;
  logic        rst_req_q;

  if (RST_WR) begin : g_rstlvl
    logic accept;
    assign accept = wr_en && (sel == SEL_RSTLVL) && lock_open;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rstlvl_q  <= '0;
        rst_req_q <= 1'b0;
      end else begin
        rst_req_q <= accept && wdata_i[TRIG_IDX];
        if (accept) rstlvl_q <= wdata_i;
      end
    end
  end else begin : g_no_rstlvl
    assign rstlvl_q  = '0;
    assign rst_req_q = 1'b0;
  end

  assign reset_req_o = rst_req_q;

  // pin status
  logic [STAT_W-1:0] stat_d, stat_q;

  always_comb begin
    stat_d         = '0;
    stat_d[0]      = card_detect_i;
    stat_d[WP_IDX] = write_prot_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  // tick count
  logic [31:0] tick_cnt;

  sysctl_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(DATA_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (tick_cnt)
  );

  // read mux and strobes
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_ID:     rd_mux = ID_VALUE;
      SEL_LED:    rd_mux = led_q;
      SEL_LOCK:   rd_mux = 32'(lock_q);
      SEL_CFG0:   rd_mux = cfg0_q;
      SEL_CFG1:   rd_mux = cfg1_q;
      SEL_FLGS:   rd_mux = flg_q[0];
      SEL_NVS:    rd_mux = flg_q[1];
      SEL_RSTLVL: rd_mux = rstlvl_q;
      SEL_ONE:    rd_mux = 32'd1;
      SEL_STAT:   rd_mux = 32'(stat_q);
      SEL_TICK:   rd_mux = tick_cnt;
      default:    rd_mux = '0;
    endcase
  end

  logic [31:0] rdata_q;
  logic        bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rd_mux;
      bad_q <= req_i && (sel == SEL_NONE);
    end
  end

  assign rdata_o    = rdata_q;
  assign bad_addr_o = bad_q;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [31:0] ID_VALUE = 32'h0100_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              reset_req_o,
  input logic              bad_addr_o
);
  import sysctl_pkg::*;

  logic rd_one, rd_id, rd_stat, rd_lock, wr_rst, wr_lock, key_q;

  assign rd_one  = req_i && !we_i && (addr_i == ADDR_W'(OFF_ONE));
  assign rd_id   = req_i && !we_i && (addr_i == ADDR_W'(OFF_ID));
  assign rd_stat = req_i && !we_i && (addr_i == ADDR_W'(OFF_STAT));
  assign rd_lock = req_i && !we_i && (addr_i == ADDR_W'(OFF_LOCK));
  assign wr_rst  = req_i && we_i && (addr_i == ADDR_W'(OFF_RSTLVL));
  assign wr_lock = req_i && we_i && (addr_i == ADDR_W'(OFF_LOCK));

  // independent view of the unlock state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      key_q <= 1'b0;
    else if (wr_lock) key_q <= (wdata_i == UNLOCK_KEY);
  end

  a_r8_req_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(wr_rst));

  a_r7_req_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(key_q));

  a_r11_bad_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_addr_o |-> $past(req_i));

  a_r2_one_reads_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_one) |-> (rdata_o == 32'd1));

  a_r2_id_reads_param: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_id) |-> (rdata_o == ID_VALUE));

  a_r10_stat_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_stat) |-> (rdata_o[31:3] == '0));

  a_r4_lock_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_lock) |-> (rdata_o[31:16] == '0));

  a_r12_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> $stable(rdata_o));
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .reset_req_o (reset_req_o),
  .bad_addr_o  (bad_addr_o)
);

// File: tb/sim_sysctl_regs.sv
`timescale 1ns/1ps
module sim_sysctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        cd = 1'b0, wp = 1'b0;
  logic [31:0] rdata [3];
  logic [31:0] led   [3];
  logic [2:0]  rreq, bad;

  logic [31:0] c_rd [3];
  logic [2:0]  c_rreq, c_bad;
  int total = 0, nbad = 0;

  always #2.5 clk = ~clk;

  sysctl_regs #(.ID_VALUE(32'h0100_0000)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata[0]), .led_o(led[0]), .card_detect_i(cd),
    .write_prot_i(wp), .reset_req_o(rreq[0]), .bad_addr_o(bad[0]));
  sysctl_regs #(.ID_VALUE(32'h0182_0000)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata[1]), .led_o(led[1]), .card_detect_i(cd),
    .write_prot_i(wp), .reset_req_o(rreq[1]), .bad_addr_o(bad[1]));
  sysctl_regs #(.ID_VALUE(32'h0190_0000)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata[2]), .led_o(led[2]), .card_detect_i(cd),
    .write_prot_i(wp), .reset_req_o(rreq[2]), .bad_addr_o(bad[2]));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(logic w, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    for (int i = 0; i < 3; i++) c_rd[i] = rdata[i];
    c_rreq = rreq;
    c_bad  = bad;
  endtask

  task automatic t_reset;
    chk("R1 rreq", 32'(rreq), 0);
    chk("R1 bad", 32'(bad), 0);
    foreach (c_rd[i]) begin end
    acc(0, 12'h008, 0); chk("R1 led", c_rd[0], 0);
    acc(0, 12'h020, 0); chk("R1 lock", c_rd[0], 0);
    acc(0, 12'h028, 0); chk("R1 cfg0", c_rd[0], 0);
    acc(0, 12'h02C, 0); chk("R1 cfg1", c_rd[0], 0);
    acc(0, 12'h030, 0); chk("R1 flags", c_rd[0], 0);
    acc(0, 12'h038, 0); chk("R1 nvflags", c_rd[0], 0);
    acc(0, 12'h040, 0); chk("R1 rstlvl", c_rd[0], 0);
  endtask

  task automatic t_id;
    acc(0, 12'h000, 0);
    chk("R2 id u0", c_rd[0], 32'h0100_0000);
    chk("R2 id u1", c_rd[1], 32'h0182_0000);
    acc(1, 12'h000, 32'hFFFF_FFFF);
    acc(0, 12'h000, 0); chk("R2 id after write", c_rd[0], 32'h0100_0000);
    acc(1, 12'h044, 32'h0);
    acc(0, 12'h044, 0); chk("R2 one", c_rd[0], 1);
  endtask

  task automatic t_rw;
    acc(1, 12'h008, 32'h0000_00A5);
    chk("R3 led_o", led[0], 32'h0000_00A5);
    acc(0, 12'h008, 0); chk("R3 led read", c_rd[0], 32'h0000_00A5);
    acc(1, 12'h028, 32'hDEAD_BEEF);
    acc(1, 12'h02C, 32'h1234_5678);
    acc(0, 12'h028, 0); chk("R3 cfg0", c_rd[0], 32'hDEAD_BEEF);
    acc(0, 12'h02C, 0); chk("R3 cfg1", c_rd[0], 32'h1234_5678);
  endtask

  task automatic t_lock;
    acc(1, 12'h020, 32'h1234_A05F);
    acc(0, 12'h020, 0); chk("R4 near key", c_rd[0], 32'h0000_205F);
    acc(1, 12'h020, 32'h0000_FFFF);
    acc(0, 12'h020, 0); chk("R4 bit15 cleared", c_rd[0], 32'h0000_7FFF);
    acc(1, 12'h020, 32'h0000_A05F);
    acc(0, 12'h020, 0); chk("R4 key stored", c_rd[0], 32'h0000_A05F);
  endtask

  task automatic t_flags(logic [11:0] so, logic [11:0] co, string tag);
    acc(1, so, 32'h0000_000F);
    acc(1, so, 32'h0000_00F0);
    acc(0, so, 0); chk({tag, " set or"}, c_rd[0], 32'h0000_00FF);
    acc(1, co, 32'h0000_003C);
    acc(0, so, 0); chk({tag, " clear"}, c_rd[0], 32'h0000_00C3);
    acc(0, co, 0); chk({tag, " clear addr reads 0"}, c_rd[0], 0);
  endtask

  task automatic t_rstlvl;
    acc(1, 12'h020, 32'h1);
    acc(1, 12'h040, 32'h104);
    chk("R7 locked no pulse", 32'(c_rreq), 0);
    acc(0, 12'h040, 0);
    chk("R7 locked u0", c_rd[0], 0);
    chk("R7 locked u1", c_rd[1], 0);
    acc(1, 12'h020, 32'h0000_A05F);
    acc(1, 12'h040, 32'h104);
    chk("R8 pulse u0 bit8", 32'(c_rreq[0]), 1);
    chk("R8 pulse u1 bit2", 32'(c_rreq[1]), 1);
    chk("R7 no pulse u2", 32'(c_rreq[2]), 0);
    @(negedge clk);
    chk("R8 one cycle", 32'(rreq), 0);
    acc(0, 12'h040, 0);
    chk("R7 stored u0", c_rd[0], 32'h104);
    chk("R7 stored u1", c_rd[1], 32'h104);
    chk("R7 ignored u2", c_rd[2], 0);
    acc(1, 12'h040, 32'h004);
    chk("R8 bit2 u0 none", 32'(c_rreq[0]), 0);
    chk("R8 bit2 u1", 32'(c_rreq[1]), 1);
    acc(1, 12'h040, 32'h100);
    chk("R8 bit8 u0", 32'(c_rreq[0]), 1);
    chk("R8 bit8 u1 none", 32'(c_rreq[1]), 0);
  endtask

  task automatic t_tick;
    logic [31:0] a;
    acc(0, 12'h05C, 0); a = c_rd[0];
    repeat (248) @(negedge clk);
    acc(0, 12'h05C, 0);
    chk("R9 tick delta", c_rd[0] - a, 30);
  endtask

  task automatic t_stat;
    cd = 1'b1; wp = 1'b1;
    acc(0, 12'h048, 0);
    chk("R10 u0 wp bit2", c_rd[0], 32'h5);
    chk("R10 u1 wp bit1", c_rd[1], 32'h3);
    chk("R10 u2 wp bit1", c_rd[2], 32'h3);
    cd = 1'b0;
    acc(1, 12'h048, 32'hFFFF_FFFF);
    acc(0, 12'h048, 0);
    chk("R10 cd low", c_rd[0], 32'h4);
    wp = 1'b0;
  endtask

  task automatic t_bad;
    acc(0, 12'h100, 0);
    chk("R11 read zero", c_rd[0], 0);
    chk("R11 bad strobe", 32'(c_bad[0]), 1);
    @(negedge clk);
    chk("R11 strobe one cycle", 32'(bad[0]), 0);
    acc(1, 12'h009, 32'hFFFF_FFFF);
    chk("R11 misaligned strobe", 32'(c_bad[0]), 1);
    acc(0, 12'h008, 0);
    chk("R11 led untouched", c_rd[0], 32'h0000_00A5);
    chk("R11 good no strobe", 32'(c_bad[0]), 0);
    acc(1, 12'h030, 32'h1);
    chk("R12 hold on write", rdata[0], 32'h0000_00A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_id();
        t_rw();
        t_lock();
        t_flags(12'h030, 12'h034, "R5");
        t_flags(12'h038, 12'h03C, "R6");
        t_rstlvl();
        t_tick();
        t_stat();
        t_bad();
      end
      begin
        repeat (100000) @(posedge clk);
        total++; nbad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, nbad);
    $finish;
  end
endmodule